// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one device function. Software reaches it through a small request/response port. A request carries a byte offset, an access size of 1, 2 or 4 bytes, a write flag and write data. Identity fields and defaults come from parameters at reset. The writable fields are the command word, cache line size, latency timer, interrupt line, the six base address registers and the expansion ROM base. Writes to any other field are dropped without complaint. The programmed base address and ROM values are driven out for the address decoders next to the block.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A write takes effect on that same edge. A read returns its data on `rsp_valid` one clock later and holds it until `rsp_ready` is high. While a response is held back, `req_ready` is low, so back-pressure from the response side stops new requests. The response side never drops data. When no response is pending, requests are accepted on every cycle.

Base address sizing follows the usual probe: writing all ones returns the inverted size mask and leaves the type bits alone. The ROM base register uses its own sizing rule. Accesses that fall outside the header, that use an illegal size, or that are misaligned raise a one-cycle error pulse and change nothing.

Top module: `cfghdr_regfile`

## Requirements
- R1: After reset, a read returns the parameter values for vendor ID (bytes 0-1), device ID (2-3), revision (8), programming interface (9), subclass (0x0A), class (0x0B), interrupt line (0x3C) and interrupt pin (0x3D). Each base address register reads as its parameter type bits. The command word, status word and ROM base read zero.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. An accepted read raises `rsp_valid` on the next clock. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` is held, `rsp_valid` stays high and `req_ready` is low.
- R3: A read returns the header bytes little-endian, starting at the offset: the byte at the offset is in bits 7:0. Bits above the access size are zero.
- R4: A 1-byte write to 0x0C (cache line size), 0x0D (latency timer) or 0x3C (interrupt line) stores the byte. A 1-byte write to any other offset changes nothing.
- R5: A 2-byte or 4-byte write at 0x04 replaces the 16-bit command word with the low 16 data bits. The status word at 0x06 stays zero.
- R6: A 4-byte write of 0xFFFFFFFF to base address register n (offset 0x10+4n, n=0..5) makes it read ~(size-1), with its type bits kept. A register of size zero then reads as its type bits only.
- R7: Any other 4-byte write to a base address register stores the data with the type bits kept from the old value. If bit 0 of the register is 1 (I/O), the type bits are bits 1:0. If bit 0 is 0 (memory), they are bits 3:0.
- R8: A 4-byte write of 0xFFFFFFFE to the ROM base (0x30) makes it read 0xFFFFFFFF. Any other 4-byte value is stored unchanged.
- R9: An access at an offset of 0x40 or above reads zero and writes nothing. `err_pulse` is high for exactly the cycle after the access is accepted.
- R10: An access with a size other than 1, 2 or 4, a 2-byte access at an odd offset, or a 4-byte access at an offset that is not a multiple of 4 raises `err_pulse` on the next cycle. Such an access changes no register, and a read returns zero.
- R11: `bar_value` bits 32n+31:32n always equal base address register n, and `rom_base` always equals the ROM base register.
- R12: A 4-byte write to a read-only word, such as offset 0x00 or 0x08, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, little-endian from the offset |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken this cycle |
| rsp_rdata | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle flag for an out-of-range or malformed access |
| bar_value | output | 32*NUM_BARS | Current base address registers, register n at bits 32n+31:32n |
| rom_base | output | 32 | Current ROM base register |

## Verification
The assertions check the following on every cycle:
- the response handshake: data held under back-pressure, and a response one cycle after every accepted read;
- that the base address type bits never move;
- that an error pulse only follows an accepted request;
- that out-of-range writes leave every register alone;
- that the ROM sizing probe reads back all ones.

Only the bench scenarios can show the byte layout of the header, the sizing masks for each register size and type, and that ignored byte and word writes really leave their fields unchanged.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int NUM_BARS = 6;
  localparam int OFF_W    = 6;

  localparam logic [OFF_W-1:0] OFF_CMD     = 6'h04;
  localparam logic [OFF_W-1:0] OFF_CACHE   = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_LAT     = 6'h0D;
  localparam logic [OFF_W-1:0] OFF_BAR0    = 6'h10;
  localparam logic [OFF_W-1:0] OFF_ROM     = 6'h30;
  localparam logic [OFF_W-1:0] OFF_INTLINE = 6'h3C;

  localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

  typedef struct packed {
    logic [15:0] cmd;
    logic [7:0]  cache_line;
    logic [7:0]  latency;
    logic [7:0]  int_line;
    logic [31:0] rom;
  } cfg_state_t;
endpackage

// File: rtl/cfg_req_decode.sv
module cfg_req_decode
  import cfg_hdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic [OFF_W-1:0]  off,
  output logic              bad
);
  logic size_ok, align_ok, range_ok;

  always_comb begin
    off      = addr[OFF_W-1:0];
    size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    align_ok = !((size == 3'd2) && addr[0]) &&
               !((size == 3'd4) && (addr[1:0] != 2'b00));
    range_ok = (addr[ADDR_W-1:OFF_W] == '0);
    bad      = !(size_ok && align_ok && range_ok);
  end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
  parameter logic [31:0] SIZE      = 32'h0,
  parameter logic [31:0] TYPE_INIT = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q
);
  localparam logic [31:0] TMASK  = TYPE_INIT[0] ? 32'h3 : 32'hF;
  localparam logic [31:0] SZMASK = ~(SIZE - 32'd1);

  logic [31:0] upper;

  always_comb begin
    if (wdata == 32'hFFFF_FFFF) upper = SZMASK;
    else                        upper = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bar_q <= TYPE_INIT & TMASK;
    else if (wr_en) bar_q <= (upper & ~TMASK) | (bar_q & TMASK);
  end

  // R7
  type_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bar_q & TMASK) == ($past(bar_q) & TMASK)));
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h0,
  parameter logic [15:0] DEVICE_ID  = 16'h0,
  parameter logic [7:0]  REVISION   = 8'h0,
  parameter logic [7:0]  PROG_IF    = 8'h0,
  parameter logic [7:0]  SUBCLASS   = 8'h0,
  parameter logic [7:0]  CLASS_CODE = 8'h0,
  parameter logic [7:0]  HDR_TYPE   = 8'h0,
  parameter logic [15:0] SUBSYS_VID = 16'h0,
  parameter logic [15:0] SUBSYS_ID  = 16'h0,
  parameter logic [7:0]  INT_PIN    = 8'h0,
  parameter logic [7:0]  MIN_GNT    = 8'h0,
  parameter logic [7:0]  MAX_LAT    = 8'h0
) (
  input  cfg_state_t                  st,
  input  logic [NUM_BARS-1:0][31:0]   bars,
  input  logic [OFF_W-1:0]            off,
  input  logic [2:0]                  size,
  output logic [31:0]                 data
);
  localparam int HDR_BYTES = 1 << OFF_W;

  logic [HDR_BYTES-1:0][7:0] img;
  logic [OFF_W-1:0] o1, o2, o3;

  always_comb begin
    img      = '0;
    img[0]   = VENDOR_ID[7:0];
    img[1]   = VENDOR_ID[15:8];
    img[2]   = DEVICE_ID[7:0];
    img[3]   = DEVICE_ID[15:8];
    img[4]   = st.cmd[7:0];
    img[5]   = st.cmd[15:8];
    img[8]   = REVISION;
    img[9]   = PROG_IF;
    img[10]  = SUBCLASS;
    img[11]  = CLASS_CODE;
    img[12]  = st.cache_line;
    img[13]  = st.latency;
    img[14]  = HDR_TYPE;
    for (int i = 0; i < NUM_BARS; i++) begin
      for (int k = 0; k < 4; k++) begin
        img[int'(OFF_BAR0) + 4*i + k] = bars[i][8*k +: 8];
      end
    end
    img[44]  = SUBSYS_VID[7:0];
    img[45]  = SUBSYS_VID[15:8];
    img[46]  = SUBSYS_ID[7:0];
    img[47]  = SUBSYS_ID[15:8];
    for (int k = 0; k < 4; k++) begin
      img[int'(OFF_ROM) + k] = st.rom[8*k +: 8];
    end
    img[60]  = st.int_line;
    img[61]  = INT_PIN;
    img[62]  = MIN_GNT;
    img[63]  = MAX_LAT;
  end

  always_comb begin
    o1 = off + 6'd1;
    o2 = off + 6'd2;
    o3 = off + 6'd3;
    case (size)
      3'd1:    data = {24'h0, img[off]};
      3'd2:    data = {16'h0, img[o1], img[off]};
      3'd4:    data = {img[o3], img[o2], img[o1], img[off]};
      default: data = 32'h0;
    endcase
  end
endmodule

// File: rtl/cfghdr_regfile.sv
module cfghdr_regfile
  import cfg_hdr_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] VENDOR_ID  = 16'h1B2C,
  parameter logic [15:0] DEVICE_ID  = 16'h0A51,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [7:0]  PROG_IF    = 8'h00,
  parameter logic [7:0]  SUBCLASS   = 8'h00,
  parameter logic [7:0]  CLASS_CODE = 8'h02,
  parameter logic [7:0]  INT_LINE   = 8'h0B,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
    {32'h0, 32'h0, 32'h0001_0000, 32'h0, 32'h0000_0100, 32'h0000_1000},
  parameter logic [NUM_BARS-1:0][31:0] BAR_TYPE =
    {32'h0, 32'h0, 32'h8, 32'h0, 32'h1, 32'h0}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [2:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [31:0]              rsp_rdata,
  output logic                     err_pulse,
  output logic [32*NUM_BARS-1:0]   bar_value,
  output logic [31:0]              rom_base
);
  logic [OFF_W-1:0]          off;
  logic                      bad;
  logic                      accept, wr_ok;
  logic [NUM_BARS-1:0]       bar_we;
  logic [NUM_BARS-1:0][31:0] bars;
  logic [31:0]               rd_data;
  cfg_state_t                st_q;

  cfg_req_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .size(req_size), .off(off), .bad(bad)
  );

  assign req_ready = !(rsp_valid && !rsp_ready);
  assign accept    = req_valid && req_ready;
  assign wr_ok     = accept && req_write && !bad;

  for (genvar n = 0; n < NUM_BARS; n++) begin : g_bar
    localparam logic [OFF_W-1:0] BOFF = OFF_BAR0 + 6'(4*n);
    assign bar_we[n] = wr_ok && (req_size == 3'd4) && (off == BOFF);
    cfg_bar_slot #(.SIZE(BAR_SIZE[n]), .TYPE_INIT(BAR_TYPE[n])) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(bar_we[n]), .wdata(req_wdata),
      .bar_q(bars[n])
    );
    assign bar_value[32*n +: 32] = bars[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.cmd        <= 16'h0;
      st_q.cache_line <= 8'h0;
      st_q.latency    <= 8'h0;
      st_q.int_line   <= INT_LINE;
      st_q.rom        <= 32'h0;
    end else if (wr_ok) begin
      case (req_size)
        3'd1: begin
          if (off == OFF_CACHE)   st_q.cache_line <= req_wdata[7:0];
          if (off == OFF_LAT)     st_q.latency    <= req_wdata[7:0];
          if (off == OFF_INTLINE) st_q.int_line   <= req_wdata[7:0];
        end
        3'd2: begin
          if (off == OFF_CMD) st_q.cmd <= req_wdata[15:0];
        end
        3'd4: begin
          if (off == OFF_CMD) st_q.cmd <= req_wdata[15:0];
          if (off == OFF_ROM)
            st_q.rom <= (req_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : req_wdata;
        end
        default: ;
      endcase
    end
  end

  assign rom_base = st_q.rom;

  cfg_rd_mux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .PROG_IF(PROG_IF), .SUBCLASS(SUBCLASS), .CLASS_CODE(CLASS_CODE),
    .HDR_TYPE(8'h00), .SUBSYS_VID(16'h0), .SUBSYS_ID(16'h0),
    .INT_PIN(INT_PIN), .MIN_GNT(8'h00), .MAX_LAT(8'h00)
  ) u_mux (
    .st(st_q), .bars(bars), .off(off), .size(req_size), .data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= accept && bad;
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= bad ? 32'h0 : rd_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R2
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_valid && req_ready));

  // R9
  oor_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (req_addr[ADDR_W-1:OFF_W] != '0))
    |=> ($stable(bar_value) && $stable(rom_base)));

  // R8
  rom_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (req_size == 3'd4) &&
     (req_addr == ADDR_W'(OFF_ROM)) && (req_wdata == ROM_PROBE))
    |=> (rom_base == 32'hFFFF_FFFF));
endmodule

// File: tb/test_cfghdr_regfile.sv
module test_cfghdr_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = 8'h0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = 32'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        err_pulse;
  logic [191:0] bar_value;
  logic [31:0] rom_base;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] q_data[$];
  bit          q_err[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  cfghdr_regfile i_cfghdr_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .err_pulse(err_pulse), .bar_value(bar_value),
    .rom_base(rom_base)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [7:0] a, input logic [2:0] s,
                       input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] s,
                    input logic [31:0] exp, input bit exp_err, input string tag);
    q_data.push_back(exp); q_err.push_back(exp_err); q_tag.push_back(tag);
    issue(1'b0, a, s, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] s,
                    input logic [31:0] d, input bit exp_err, input string tag);
    issue(1'b1, a, s, d);
    chk(err_pulse == exp_err, {tag, " err"}, 32'(err_pulse), 32'(exp_err));
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R2 unexpected response", rsp_rdata, 32'h0);
      end else begin
        automatic logic [31:0] e = q_data.pop_front();
        automatic bit ee = q_err.pop_front();
        automatic string t = q_tag.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
        chk(err_pulse == ee, {t, " err"}, 32'(err_pulse), 32'(ee));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    chk(rsp_valid == 1'b0 && err_pulse == 1'b0, "R1 idle outputs", 32'(rsp_valid), 32'h0);
    chk(rom_base == 32'h0, "R1 rom reset", rom_base, 32'h0);
    chk(bar_value[63:32] == 32'h1, "R1 bar1 io type", bar_value[63:32], 32'h1);
    rd(8'h00, 3'd4, 32'h0A51_1B2C, 1'b0, "R1 ids");
    rd(8'h08, 3'd4, 32'h0200_0003, 1'b0, "R1 class/rev");
    rd(8'h3C, 3'd2, 32'h0000_010B, 1'b0, "R1 int line/pin");
    rd(8'h04, 3'd4, 32'h0, 1'b0, "R1 cmd/status zero");
    rd(8'h1C, 3'd4, 32'h8, 1'b0, "R1 bar3 type");
    // R3 byte lanes
    rd(8'h02, 3'd1, 32'h51, 1'b0, "R3 byte read");
    rd(8'h02, 3'd2, 32'h0A51, 1'b0, "R3 half read");
    rd(8'h3D, 3'd1, 32'h01, 1'b0, "R3 pin byte");
    // R4 byte writes
    wr(8'h0C, 3'd1, 32'h10, 1'b0, "R4 cache");
    wr(8'h0D, 3'd1, 32'h40, 1'b0, "R4 latency");
    rd(8'h0C, 3'd4, 32'h0000_4010, 1'b0, "R4 cache/lat read");
    wr(8'h3C, 3'd1, 32'h05, 1'b0, "R4 int line");
    wr(8'h3D, 3'd1, 32'h77, 1'b0, "R4 pin ignored");
    wr(8'h08, 3'd1, 32'hAA, 1'b0, "R4 rev ignored");
    rd(8'h3C, 3'd2, 32'h0000_0105, 1'b0, "R4 line/pin read");
    rd(8'h08, 3'd4, 32'h0200_0003, 1'b0, "R4 rev unchanged");
    // R12 read-only words
    wr(8'h00, 3'd4, 32'hFFFF_FFFF, 1'b0, "R12 id write");
    rd(8'h00, 3'd4, 32'h0A51_1B2C, 1'b0, "R12 id unchanged");
    // R5 command
    wr(8'h04, 3'd4, 32'hFFFF_0146, 1'b0, "R5 cmd word");
    rd(8'h04, 3'd4, 32'h0000_0146, 1'b0, "R5 status stays zero");
    wr(8'h04, 3'd2, 32'h0007, 1'b0, "R5 cmd half");
    rd(8'h04, 3'd2, 32'h0007, 1'b0, "R5 cmd half read");
    // R6 sizing
    wr(8'h10, 3'd4, 32'hFFFF_FFFF, 1'b0, "R6 probe bar0");
    wr(8'h14, 3'd4, 32'hFFFF_FFFF, 1'b0, "R6 probe bar1");
    wr(8'h18, 3'd4, 32'hFFFF_FFFF, 1'b0, "R6 probe bar2");
    wr(8'h1C, 3'd4, 32'hFFFF_FFFF, 1'b0, "R6 probe bar3");
    rd(8'h10, 3'd4, 32'hFFFF_F000, 1'b0, "R6 bar0 mask");
    rd(8'h14, 3'd4, 32'hFFFF_FF01, 1'b0, "R6 bar1 io mask");
    rd(8'h18, 3'd4, 32'h0, 1'b0, "R6 bar2 unused");
    rd(8'h1C, 3'd4, 32'hFFFF_0008, 1'b0, "R6 bar3 mask");
    // R7 programming
    wr(8'h10, 3'd4, 32'h8000_1237, 1'b0, "R7 bar0 write");
    wr(8'h14, 3'd4, 32'h0000_C0FE, 1'b0, "R7 bar1 write");
    wr(8'h1C, 3'd4, 32'h4000_0005, 1'b0, "R7 bar3 write");
    rd(8'h10, 3'd4, 32'h8000_1230, 1'b0, "R7 bar0 mem mask");
    rd(8'h14, 3'd4, 32'h0000_C0FD, 1'b0, "R7 bar1 io mask");
    // R11 export
    chk(bar_value[31:0] == 32'h8000_1230, "R11 bar0 port", bar_value[31:0], 32'h8000_1230);
    chk(bar_value[63:32] == 32'h0000_C0FD, "R11 bar1 port", bar_value[63:32], 32'h0000_C0FD);
    chk(bar_value[127:96] == 32'h4000_0008, "R11 bar3 port", bar_value[127:96], 32'h4000_0008);
    // R8 ROM
    wr(8'h30, 3'd4, 32'hFFFF_FFFE, 1'b0, "R8 rom probe");
    rd(8'h30, 3'd4, 32'hFFFF_FFFF, 1'b0, "R8 rom probe read");
    chk(rom_base == 32'hFFFF_FFFF, "R11 rom port", rom_base, 32'hFFFF_FFFF);
    wr(8'h30, 3'd4, 32'h1234_5679, 1'b0, "R8 rom store");
    rd(8'h30, 3'd4, 32'h1234_5679, 1'b0, "R8 rom read");
    // R9 out of range
    rd(8'h40, 3'd4, 32'h0, 1'b1, "R9 oor read");
    wr(8'h50, 3'd4, 32'hDEAD_BEEF, 1'b1, "R9 oor write");
    chk(rom_base == 32'h1234_5679, "R9 rom untouched", rom_base, 32'h1234_5679);
    chk(bar_value[31:0] == 32'h8000_1230, "R9 bar untouched", bar_value[31:0], 32'h8000_1230);
    @(negedge clk);
    chk(err_pulse == 1'b0, "R9 pulse one cycle", 32'(err_pulse), 32'h0);
    // R10 malformed
    wr(8'h3C, 3'd3, 32'h99, 1'b1, "R10 size 3");
    rd(8'h3C, 3'd1, 32'h05, 1'b0, "R10 line unchanged");
    wr(8'h31, 3'd4, 32'h0, 1'b1, "R10 misaligned word");
    chk(rom_base == 32'h1234_5679, "R10 rom unchanged", rom_base, 32'h1234_5679);
    rd(8'h3D, 3'd2, 32'h0, 1'b1, "R10 misaligned half read");
    // R2 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    rd(8'h00, 3'd4, 32'h0A51_1B2C, 1'b0, "R2 held read");
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b1, "R2 valid held", 32'(rsp_valid), 32'h1);
    chk(req_ready == 1'b0, "R2 ready low", 32'(req_ready), 32'h0);
    chk(rsp_rdata == 32'h0A51_1B2C, "R2 data held", rsp_rdata, 32'h0A51_1B2C);
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(q_data.size() == 0, "R2 scoreboard drained", 32'(q_data.size()), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule